// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block keeps one 32-bit status and control word that tells software why the system last came out of reset, and lets software ask for a new reset. The five upper bits carry the meaning. Bits 26:0 are not stored and always read back as zero. Three of the five bits are status flags that software clears by writing 1. Two are request bits that software sets by writing 1. A write that sets a request bit also sends a one-cycle reset-request pulse to the system reset sequencer.

A small event counter tracks how many system reset events have happened since power-up. On a reset event, the word is reloaded with only the power-on flag set, but only while the counter reads zero. The counter then advances and saturates at its maximum. A soft power-on request sets the counter back to zero, so the reset that follows reports itself as a power-on reset again.

The word is mapped in an 8-byte window. It sits at the word with address bit 2 set. The other word reads as zero and ignores writes.

Top module: `rsc_reset_ctl`

## Requirements
- R1: After `rst_n` is released, the word reads 0x00000000 and `rst_req` and `rst_req_por` are low.
- R2: With `bus_addr[2]` = 0, `bus_rdata` is zero. A write there changes no bit of the word and raises no request.
- R3: Writing 1 to bit 31 (power-on flag), bit 28 or bit 27 clears that bit on the next clock. Writing 0 to these bits leaves them unchanged.
- R4: Writing 1 to bit 30 (soft power-on request) or bit 29 (soft external request) sets that bit. Writing 0 to them does not clear them.
- R5: Bits 26:0 always read as zero, whatever value is written.
- R6: A write with bit 30 set makes `rst_req` and `rst_req_por` high for exactly the one cycle after the write edge, and returns the event counter to zero.
- R7: A write with bit 29 set and bit 30 clear makes `rst_req` high for one cycle with `rst_req_por` low, and leaves the event counter unchanged.
- R8: When bits 30 and 29 are written as 1 together, the power-on kind wins: `rst_req_por` is high along with `rst_req`.
- R9: On a `sys_evt` cycle where the event counter is zero, the word becomes exactly 0x80000000. On a `sys_evt` cycle where the counter is nonzero, the word is unchanged. Every event advances the counter.
- R10: The event counter saturates at 2^CNT_W-1 and does not wrap. After more than 2^CNT_W events, a further event still leaves the word unchanged.
- R11: If `sys_evt` and a bus write fall in the same cycle, the event is handled and the write is dropped: no request pulse and no bit change from the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset; clears the word and the event counter |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address within the 8-byte window; bit 2 selects the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| sys_evt | input | 1 | One-cycle marker of a system reset event |
| rst_req | output | 1 | One-cycle reset request pulse |
| rst_req_por | output | 1 | High with `rst_req` when the request is a power-on kind |

## Verification
The event counter has no read path. A wrong counter value therefore stays hidden until the next `sys_evt`. It then shows up as a wrong reload of the word: a missing or unwanted 0x80000000, visible on a read in the cycle after the event edge. The bench forces this in three ways: it clears the counter through a soft power-on request, it runs the counter past its wrap point, and it checks that a soft external request does not clear it. A wrong flag bit or a wrong request decision shows up in the very next cycle, on `bus_rdata` or on the request pulse.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int STAT_W       = 5;
    // positions inside the 5-bit field (field bit 4 = word bit 31)
    localparam int POS_POR_FLAG = 4;
    localparam int POS_SOFT_POR = 3;
    localparam int POS_SOFT_XIR = 2;
    localparam logic [STAT_W-1:0] W1C_MASK = 5'b10011;
    localparam logic [STAT_W-1:0] SET_MASK = 5'b01100;
    localparam logic [STAT_W-1:0] POR_LOAD = 5'b10000;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              req;
        logic              req_por;
    } rsc_state_t;
endpackage

// File: rtl/rsc_bus_decode.sv
module rsc_bus_decode
    import rsc_pkg::*;
(
    input  logic              we,
    input  logic              word_sel,
    input  logic [STAT_W-1:0] field,
    output logic              wr_hit,
    output logic [STAT_W-1:0] clr_bits,
    output logic [STAT_W-1:0] set_bits,
    output logic              ask_por,
    output logic              ask_xir
);
    assign wr_hit = we & word_sel;

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        assign clr_bits[b] = wr_hit & field[b] & W1C_MASK[b];
        assign set_bits[b] = wr_hit & field[b] & SET_MASK[b];
    end

    assign ask_por = set_bits[POS_SOFT_POR];
    assign ask_xir = set_bits[POS_SOFT_XIR];
endmodule

// File: rtl/rsc_evt_counter.sv
module rsc_evt_counter #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic is_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && (cnt_q != CNT_MAX))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign is_zero = (cnt_q == '0);

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && inc && !clr) |=> (cnt_q == CNT_MAX));

    assert_clear_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> is_zero);
endmodule

// File: rtl/rsc_reset_ctl.sv
module rsc_reset_ctl
    import rsc_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 3,
    parameter int WORD_SEL_BIT = 2,
    parameter int CNT_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sys_evt,
    output logic              rst_req,
    output logic              rst_req_por
);
    localparam int STAT_LSB = DATA_W - STAT_W;

    rsc_state_t st_d, st_q;

    logic              wr_hit, ask_por, ask_xir;
    logic [STAT_W-1:0] clr_bits, set_bits;
    logic              cnt_zero, cnt_inc, cnt_clr;
    logic              word_sel;

    logic unused_inputs;
    assign unused_inputs = ^{bus_wdata[STAT_LSB-1:0], bus_addr};

    assign word_sel = bus_addr[WORD_SEL_BIT];

    rsc_bus_decode u_dec (
        .we       (bus_we),
        .word_sel (word_sel),
        .field    (bus_wdata[DATA_W-1:STAT_LSB]),
        .wr_hit   (wr_hit),
        .clr_bits (clr_bits),
        .set_bits (set_bits),
        .ask_por  (ask_por),
        .ask_xir  (ask_xir)
    );

    rsc_evt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (cnt_inc),
        .clr     (cnt_clr),
        .is_zero (cnt_zero)
    );

    always_comb begin
        st_d         = st_q;
        st_d.req     = 1'b0;
        st_d.req_por = 1'b0;
        cnt_inc      = 1'b0;
        cnt_clr      = 1'b0;
        if (sys_evt) begin
            cnt_inc = 1'b1;
            if (cnt_zero)
                st_d.stat = POR_LOAD;
        end else if (wr_hit) begin
            st_d.stat = (st_q.stat & ~clr_bits) | set_bits;
            if (ask_por) begin
                st_d.req     = 1'b1;
                st_d.req_por = 1'b1;
                cnt_clr      = 1'b1;
            end else if (ask_xir) begin
                st_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (word_sel)
            bus_rdata[DATA_W-1:STAT_LSB] = st_q.stat;
    end

    assign rst_req     = st_q.req;
    assign rst_req_por = st_q.req_por;

    assert_req_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(bus_we && word_sel && !sys_evt));

    assert_por_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_por |-> rst_req);

    assert_first_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_evt && cnt_zero) |=> (st_q.stat == POR_LOAD));

    assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_evt && !cnt_zero) |=> ($stable(st_q.stat) && !rst_req));

    assert_other_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !word_sel |-> (bus_rdata == '0));

    assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[STAT_LSB-1:0] == '0);
endmodule

// File: tb/rsc_reset_ctl_tb.sv
module rsc_reset_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic        req;
        logic        por;
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_evt = 1'b0;
    logic        rst_req, rst_req_por;
    logic        mon_req = 1'b0;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsc_reset_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_evt(sys_evt),
        .rst_req(rst_req), .rst_req_por(rst_req_por)
    );

    // monitor: compare outputs against the scoreboard at the falling edge
    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if ({rst_req, rst_req_por, bus_rdata} !== {e.req, e.por, e.data}) begin
                n_bad++;
                $display("FAIL %s: got req=%b por=%b data=%h, expected req=%b por=%b data=%h",
                         e.tag, rst_req, rst_req_por, bus_rdata, e.req, e.por, e.data);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles, expected under %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic evt);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; sys_evt = evt;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0; sys_evt = 1'b0;
    endtask

    task automatic evt();
        @(posedge clk); #1;
        sys_evt = 1'b1;
        @(posedge clk); #1;
        sys_evt = 1'b0;
    endtask

    // driver: push expectation, present read address for one cycle
    task automatic chk(input logic [2:0] a, input logic rq, input logic pr,
                       input logic [31:0] d, input string tag);
        exp_t e;
        e.req = rq; e.por = pr; e.data = d; e.tag = tag;
        exp_q.push_back(e);
        bus_addr = a;
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk(3'd4, 0, 0, 32'h0, "R1 reset word");
        chk(3'd0, 0, 0, 32'h0, "R2 other word reads zero");

        evt();
        chk(3'd4, 0, 0, 32'h8000_0000, "R9 first event loads power-on flag");
        wr(3'd4, 32'h07FF_FFFF, 0);
        chk(3'd4, 0, 0, 32'h8000_0000, "R5 low bits ignored");
        wr(3'd4, 32'h0, 0);
        chk(3'd4, 0, 0, 32'h8000_0000, "R3 zero write keeps flag");
        wr(3'd4, 32'h8000_0000, 0);
        chk(3'd4, 0, 0, 32'h0, "R3 write one clears flag");
        wr(3'd0, 32'h6000_0000, 0);
        chk(3'd4, 0, 0, 32'h0, "R2 write to other word ignored");

        evt();
        chk(3'd4, 0, 0, 32'h0, "R9 later event leaves word");

        wr(3'd4, 32'h2000_0000, 0);
        chk(3'd4, 1, 0, 32'h2000_0000, "R7 external request pulse");
        chk(3'd4, 0, 0, 32'h2000_0000, "R7 pulse lasts one cycle");
        evt();
        chk(3'd4, 0, 0, 32'h2000_0000, "R7 counter not cleared");
        wr(3'd4, 32'h0, 0);
        chk(3'd4, 0, 0, 32'h2000_0000, "R4 zero write keeps request bit");

        for (int i = 0; i < 20; i++) evt();
        chk(3'd4, 0, 0, 32'h2000_0000, "R10 counter saturates");

        wr(3'd4, 32'h4000_0000, 0);
        chk(3'd4, 1, 1, 32'h6000_0000, "R6 power-on request pulse");
        chk(3'd4, 0, 0, 32'h6000_0000, "R6 pulse lasts one cycle");
        evt();
        chk(3'd4, 0, 0, 32'h8000_0000, "R6 counter cleared so event reloads");

        wr(3'd4, 32'h6000_0000, 0);
        chk(3'd4, 1, 1, 32'hE000_0000, "R8 both bits give power-on kind");

        wr(3'd4, 32'h8000_0000, 1);
        chk(3'd4, 0, 0, 32'h8000_0000, "R11 event wins over write");
        evt();
        chk(3'd4, 0, 0, 32'h8000_0000, "R11 counter advanced by event");

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule